// File: doc/BRIEF.md
# One-Shot Event Timer with Free-Running Timebase

This block is a register-mapped timer unit for a processor subsystem. It combines a programmable down-counter, which signals one event when it runs out, with a free-running timestamp counter. Both advance on every cycle of the block clock, which is the 100 MHz time tick, so one count is 10 ns. Software writes a reload value, issues a load operation to copy it into the counter, and then issues a run operation. It can freeze the counter at any time with a hold operation and read the live count back. The elapsed time since the start is the reload value minus the live count.

When the counter steps from one to zero while running, the unit latches a pending-event flag and the counter stays at zero until the next load. The pending flag is combined with an enable bit to drive the interrupt output. Software clears the flag by writing a one to an acknowledge location. The timestamp counter runs from reset onward and wraps at its full width. Software reads it to build a monotonic clock.

Register access uses a single-cycle write strobe with a word address. Reads are combinational from the address.

Top module: `otmr_unit`

## Requirements
- R1: While reset is asserted and after its release before any write, every readable register reads 0 (the timestamp only until its first clock), the operation is hold and `irq_o` is 0.
- R2: Writing operation code 1 (load) to bits [1:0] of the control register (address 0x1) copies the reload register (address 0x0) into the counter at that clock edge. The count does not change while the operation stays load.
- R3: While the operation is run (code 2) and the count is not zero, the count falls by exactly one per clock. The count register (address 0x2) returns the live value, so reload minus count equals the cycles elapsed since run took effect.
- R4: With operation hold (code 0), or the reserved code 3 which acts as hold, the count stays frozen. The edge that writes hold still applies the previous operation.
- R5: The clock edge at which a running count goes from 1 to 0 sets bit 0 of the raw status register (address 0x5). The count then stays at 0 with no further events until a new load.
- R6: The timestamp register (address 0x3) increments by one every clock and wraps from its all-ones value to 0. Its width is set by `TIME_W`, and it is zero-extended on reads.
- R7: Bit 0 of the mask register (address 0x4) is read/write. The masked status register (address 0x6) returns raw AND mask, and `irq_o` equals that masked bit.
- R8: Writing 1 to bit 0 of the acknowledge location (address 0x7) clears the raw status, and writing 0 there has no effect. An expiry at the same edge as an acknowledge leaves the status set.
- R9: The acknowledge location and unmapped addresses read 0. Writes to the read-only count, timestamp and status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz time tick and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt, raw status AND enable |

## Verification
The hardest case to reach is an acknowledge write that lands on the same edge as the expiry. The flag must then stay set, yet a write one cycle off would look correct from the ports. The bench reaches this edge by counting cycles from the run write with the rule that expiry follows it by exactly the reload value. It also checks the count one cycle before the edge to confirm the alignment. The hold write that lands on a running count is placed with the same counting, so the bench can tell whether that edge still decrements. Timestamp wrap is reached by building the bench with a narrow timestamp.

// File: rtl/otmr_pkg.sv
package otmr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2
  } op_e;

  localparam logic [3:0] A_RELOAD = 4'h0;
  localparam logic [3:0] A_CTRL   = 4'h1;
  localparam logic [3:0] A_COUNT  = 4'h2;
  localparam logic [3:0] A_TIME   = 4'h3;
  localparam logic [3:0] A_MASK   = 4'h4;
  localparam logic [3:0] A_RAW    = 4'h5;
  localparam logic [3:0] A_MSKD   = 4'h6;
  localparam logic [3:0] A_ACK    = 4'h7;

  // Reserved code 3 is folded onto hold.
  function automatic op_e decode_op(input logic [1:0] field);
    case (field)
      2'd1:    return OP_LOAD;
      2'd2:    return OP_RUN;
      default: return OP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/otmr_countdown.sv
module otmr_countdown
  import otmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  op_e              op_new,
  input  logic [CNT_W-1:0] reload_q,
  output op_e              op_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             ld_evt;
  logic [CNT_W-1:0] count_d;

  function automatic logic [CNT_W-1:0] step_count(input op_e op, input logic [CNT_W-1:0] c);
    if (op == OP_RUN && c != '0) return c - ONE;
    return c;
  endfunction

  assign ld_evt  = ctrl_wr && (op_new == OP_LOAD);
  assign count_d = ld_evt ? reload_q : step_count(op_q, count_q);
  assign expire  = (op_q == OP_RUN) && (count_q == ONE) && !ld_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_HOLD;
      count_q <= '0;
    end else begin
      if (ctrl_wr) op_q <= op_new;
      count_q <= count_d;
    end
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> count_q == $past(reload_q)); // R2

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_RUN && !ld_evt && count_q != '0) |=> count_q == $past(count_q) - ONE); // R3

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_RUN && !ld_evt) |=> $stable(count_q)); // R4

  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == '0 && !expire)); // R5

endmodule

// File: rtl/otmr_timebase.sv
module otmr_timebase #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] time_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + TIME_W'(1);
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> time_q == $past(time_q) + TIME_W'(1)); // R6

endmodule

// File: rtl/otmr_irq.sv
module otmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_one,
  input  logic mask_wr,
  input  logic mask_bit,
  output logic raw_q,
  output logic mask_q,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (expire)       raw_q <= 1'b1;
      else if (ack_one) raw_q <= 1'b0;
      if (mask_wr) mask_q <= mask_bit;
    end
  end

  assign irq = raw_q & mask_q;

  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_one && !expire) |=> !raw_q); // R8

  AST_RAW_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_q && !expire) |=> !raw_q); // R5

endmodule

// File: rtl/otmr_unit.sv
module otmr_unit
  import otmr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int TIME_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);

  logic [DW-1:0]     reload_q;
  logic [DW-1:0]     count_q;
  logic [TIME_W-1:0] time_q;
  op_e               op_q;
  logic              expire, raw_q, mask_q;
  logic              wr_reload, wr_ctrl, wr_mask, ack_one;

  assign wr_reload = reg_wr && (reg_addr == AW'(A_RELOAD));
  assign wr_ctrl   = reg_wr && (reg_addr == AW'(A_CTRL));
  assign wr_mask   = reg_wr && (reg_addr == AW'(A_MASK));
  assign ack_one   = reg_wr && (reg_addr == AW'(A_ACK)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= reg_wdata;
  end

  otmr_countdown #(.CNT_W(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl),
    .op_new   (decode_op(reg_wdata[1:0])),
    .reload_q (reload_q),
    .op_q     (op_q),
    .count_q  (count_q),
    .expire   (expire)
  );

  otmr_timebase #(.TIME_W(TIME_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .time_q (time_q)
  );

  otmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .ack_one  (ack_one),
    .mask_wr  (wr_mask),
    .mask_bit (reg_wdata[0]),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq      (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(A_RELOAD): reg_rdata = reload_q;
      AW'(A_CTRL):   reg_rdata = DW'(op_q);
      AW'(A_COUNT):  reg_rdata = count_q;
      AW'(A_TIME):   reg_rdata = DW'(time_q);
      AW'(A_MASK):   reg_rdata = DW'(mask_q);
      AW'(A_RAW):    reg_rdata = DW'(raw_q);
      AW'(A_MSKD):   reg_rdata = DW'(raw_q & mask_q);
      default:       reg_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q && raw_q)); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (op_q == OP_HOLD && !irq_o)); // R1

endmodule

// File: tb/otmr_unit_bench.sv
module otmr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  otmr_unit #(.DW(32), .AW(4), .TIME_W(TW)) u_otmr_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge, returns at the following negedge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] elapsed(input logic [31:0] rl, input logic [31:0] c);
    return rl - c;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v, t0;
    // R1: reset values, read while reset held
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h1, v); check("R1 op hold after reset", v, 32'h0);
    rd(4'h2, v); check("R1 count after reset", v, 32'h0);

    // R2/R3/R4: long reload, partial run, hold
    wr(4'h0, 32'd1000);
    rd(4'h0, v); check("R2 reload readback", v, 32'd1000);
    wr(4'h1, 32'd1);
    rd(4'h2, v); check("R2 load copies", v, 32'd1000);
    idle(6);
    rd(4'h2, v); check("R2 load holds", v, 32'd1000);
    wr(4'h1, 32'd2);
    rd(4'h2, v); check("R3 run takes effect after edge", v, 32'd1000);
    idle(37);
    rd(4'h2, v); check("R3 elapsed", elapsed(32'd1000, v), 32'd37);
    wr(4'h1, 32'd0);
    rd(4'h2, v); check("R4 hold edge still steps", v, 32'd962);
    idle(9);
    rd(4'h2, v); check("R4 hold frozen", v, 32'd962);
    wr(4'h1, 32'd2); idle(2);
    wr(4'h1, 32'd3);
    rd(4'h2, v); check("R4 code3 edge steps", v, 32'd959);
    idle(5);
    rd(4'h2, v); check("R4 code3 frozen", v, 32'd959);
    rd(4'h1, v); check("R4 code3 reads hold", v, 32'd0);
    wr(4'h2, 32'h55); wr(4'h3, 32'h0); wr(4'h5, 32'h1); wr(4'h6, 32'h1);
    rd(4'h2, v); check("R9 count not writable", v, 32'd959);
    rd(4'h5, v); check("R9 raw not writable", v, 32'd0);

    // R5/R7/R8: sweep small reloads through expiry
    for (int d = 1; d <= 9; d++) begin
      wr(4'h0, 32'(d));
      wr(4'h1, 32'd1);
      wr(4'h1, 32'd2);
      if (d > 1) begin
        idle(d - 1);
        rd(4'h2, v); check("R5 one before expiry", v, 32'd1);
        rd(4'h5, v); check("R5 no early status", v, 32'd0);
        idle(1);
      end else idle(1);
      rd(4'h2, v); check("R5 count zero at expiry", v, 32'd0);
      rd(4'h5, v); check("R5 status set at expiry", v, 32'd1);
      idle(4);
      rd(4'h2, v); check("R5 stays zero", v, 32'd0);
      rd(4'h6, v); check("R7 masked off", v, 32'd0);
      check("R7 irq masked off", {31'b0, irq_o}, 32'd0);
      wr(4'h4, 32'd1);
      rd(4'h4, v); check("R7 mask readback", v, 32'd1);
      rd(4'h6, v); check("R7 masked on", v, 32'd1);
      check("R7 irq on", {31'b0, irq_o}, 32'd1);
      wr(4'h7, 32'hFFFF_FFFE);
      rd(4'h5, v); check("R8 ack zero no effect", v, 32'd1);
      rd(4'h7, v); check("R9 ack reads zero", v, 32'd0);
      wr(4'h7, 32'd1);
      rd(4'h5, v); check("R8 ack clears", v, 32'd0);
      check("R8 irq drops", {31'b0, irq_o}, 32'd0);
      idle(3);
      rd(4'h5, v); check("R5 no second event", v, 32'd0);
      wr(4'h4, 32'd0);
    end

    // R8: acknowledge on the expiry edge
    for (int d = 2; d <= 5; d++) begin
      wr(4'h0, 32'(d));
      wr(4'h1, 32'd1);
      wr(4'h1, 32'd2);
      idle(d - 1);
      rd(4'h2, v); check("R8 aligned one cycle before", v, 32'd1);
      wr(4'h7, 32'd1);
      rd(4'h5, v); check("R8 expiry wins over ack", v, 32'd1);
      wr(4'h7, 32'd1);
      rd(4'h5, v); check("R8 later ack clears", v, 32'd0);
    end

    // R6: timestamp step and wrap at TW bits
    rd(4'h3, t0);
    idle(1);
    rd(4'h3, v); check("R6 step", v, 32'((t0 + 1) % (1 << TW)));
    rd(4'h3, t0);
    idle(5000);
    rd(4'h3, v); check("R6 wrap", v, 32'((t0 + 5000) % (1 << TW)));
    rd(4'hC, v); check("R9 unmapped reads zero", v, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule